// File: doc/BRIEF.md
# Status Flags and Condition Tester

This block keeps the processor status word of a microprogrammed datapath and turns it into a single condition bit for the microprogram sequencer. The status word holds four arithmetic flags (overflow, negative, carry, zero), a link bit and three user flags. The arithmetic flags are loaded from the ALU when the microword's status-enable bit is high. Dedicated microinstruction commands set or clear fixed groups of flags.

A 4-bit test select picks one of twelve conditions. These are either single flags or combinations used for signed and unsigned comparisons. The result is driven combinationally onto the condition output. The full status word is also presented, zero-extended to the data width, so that a save-status operation can copy it to a register, the accumulator or the output bus.

Top module: `flag_test_unit`

## Requirements
- R1: An active-low asynchronous reset clears all eight flags, so the status word reads 0.
- R2: When `stat_en_i` is 1 at a clock edge, the arithmetic flags load from `alu_flags_i`, where bit 3 is overflow, bit 2 is negative, bit 1 is carry and bit 0 is zero. Link and user flags are not changed by this load.
- R3: When `stat_en_i` is 0 and no command is given, every flag holds its value across the edge.
- R4: A set command (`set_i`=1) acts on the group named by `grp_code_i`. Code 3 sets overflow, negative, carry and zero together. Code 5 sets link, code 6 sets user flag 1, code 9 sets user flag 2, and code 10 sets user flag 3. Every other code changes nothing.
- R5: A clear command (`clr_i`=1) uses the same group codes as R4 but clears the selected flags. Every other code changes nothing.
- R6: If set and clear are both given in one cycle, the selected flags end up set.
- R7: A group command applies after the ALU load in the same cycle. Code 3 therefore overrides the load. Any other code leaves the load of the four arithmetic flags in effect.
- R8: `stat_word_o` carries zero in bit 0, carry in bit 1, negative in bit 2, overflow in bit 3, link in bit 4, and user flags 1, 2 and 3 in bits 5, 6 and 7. All higher bits are 0.
- R9: The test selects are: 0 gives (N xor OVR) or Z; 1 gives N xor OVR; 2 gives Z; 3 gives OVR; 4 gives (not C) or Z; 5 gives C; 6 gives Z or C; 7 gives N.
- R10: Test select 8 gives link, 9 gives user flag 1, 10 gives user flag 2 and 11 gives user flag 3. Selects 12 to 15 give 0.
- R11: `cond_o` is combinational from the stored flags and `test_sel_i`, and follows a change of select without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_flags_i | input | 4 | ALU flags {ovr, n, c, z} |
| stat_en_i | input | 1 | Load ALU flags at this edge |
| set_i | input | 1 | Set the group selected by grp_code_i |
| clr_i | input | 1 | Clear the group selected by grp_code_i |
| grp_code_i | input | 5 | Flag group code for set/clear |
| test_sel_i | input | 4 | Condition select |
| cond_o | output | 1 | Selected condition is true |
| stat_word_o | output | DATA_W | Status word for the save path |

## Verification
The bench loads all sixteen arithmetic flag patterns and, for each one, sweeps all sixteen test selects. A swapped or inverted term in a combined condition, such as using C instead of not-C in the unsigned test, would give a wrong condition bit for some pattern. All 32 group codes are tried as set and as clear commands, starting from all-clear and from all-set. A decoder that misreads a code, or touches a neighbouring flag, would show up in the saved word. The bench also gives both commands at once, and a command together with an ALU load. A wrong ordering would either let the ALU load defeat a group-3 clear or let a link command block the load of the arithmetic flags.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int CODE_W = 5;
  localparam int SEL_W  = 4;
  localparam int FLAG_W = 8;
  localparam int ARITH_W = 4;

  localparam logic [CODE_W-1:0] GRP_ARITH = 5'd3;
  localparam logic [CODE_W-1:0] GRP_LINK  = 5'd5;
  localparam logic [CODE_W-1:0] GRP_USR1  = 5'd6;
  localparam logic [CODE_W-1:0] GRP_USR2  = 5'd9;
  localparam logic [CODE_W-1:0] GRP_USR3  = 5'd10;

  // packed order fixes save-word layout: bit0 = zro ... bit7 = usr3
  typedef struct packed {
    logic usr3;
    logic usr2;
    logic usr1;
    logic lnk;
    logic ovr;
    logic neg;
    logic cry;
    logic zro;
  } flags_t;

  typedef enum logic [SEL_W-1:0] {
    TS_SLE  = 4'h0,
    TS_SLT  = 4'h1,
    TS_EQ   = 4'h2,
    TS_OVF  = 4'h3,
    TS_ULE  = 4'h4,
    TS_CRY  = 4'h5,
    TS_ZORC = 4'h6,
    TS_NEG  = 4'h7,
    TS_LNK  = 4'h8,
    TS_USR1 = 4'h9,
    TS_USR2 = 4'hA,
    TS_USR3 = 4'hB
  } test_sel_e;
endpackage

// File: rtl/flag_grp_dec.sv
module flag_grp_dec
  import flag_pkg::*;
(
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output flags_t            mask_o
);
  always_comb begin
    mask_o = '0;
    if (en_i) begin
      unique case (code_i)
        GRP_ARITH: begin
          mask_o.ovr = 1'b1;
          mask_o.neg = 1'b1;
          mask_o.cry = 1'b1;
          mask_o.zro = 1'b1;
        end
        GRP_LINK: mask_o.lnk  = 1'b1;
        GRP_USR1: mask_o.usr1 = 1'b1;
        GRP_USR2: mask_o.usr2 = 1'b1;
        GRP_USR3: mask_o.usr3 = 1'b1;
        default:  mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_en_i,
  input  logic [ARITH_W-1:0] alu_flags_i,
  input  flags_t             set_mask_i,
  input  flags_t             clr_mask_i,
  output flags_t             q_o
);
  flags_t q, after_ld, nxt;

  // ALU load first, then group commands; set beats clear
  always_comb begin
    after_ld = q;
    if (ld_en_i) begin
      after_ld.ovr = alu_flags_i[3];
      after_ld.neg = alu_flags_i[2];
      after_ld.cry = alu_flags_i[1];
      after_ld.zro = alu_flags_i[0];
    end
    nxt = (after_ld & ~clr_mask_i) | set_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/flag_cond_mux.sv
module flag_cond_mux
  import flag_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cond_o
);
  localparam int N_SEL = 1 << SEL_W;

  logic [N_SEL-1:0] tv;
  logic             sgn_lt;

  assign sgn_lt = flags_i.neg ^ flags_i.ovr;

  always_comb begin
    tv           = '0;
    tv[TS_SLE]   = sgn_lt | flags_i.zro;
    tv[TS_SLT]   = sgn_lt;
    tv[TS_EQ]    = flags_i.zro;
    tv[TS_OVF]   = flags_i.ovr;
    tv[TS_ULE]   = ~flags_i.cry | flags_i.zro;
    tv[TS_CRY]   = flags_i.cry;
    tv[TS_ZORC]  = flags_i.zro | flags_i.cry;
    tv[TS_NEG]   = flags_i.neg;
    tv[TS_LNK]   = flags_i.lnk;
    tv[TS_USR1]  = flags_i.usr1;
    tv[TS_USR2]  = flags_i.usr2;
    tv[TS_USR3]  = flags_i.usr3;
  end

  assign cond_o = tv[sel_i];
endmodule

// File: rtl/flag_test_unit.sv
module flag_test_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ARITH_W-1:0] alu_flags_i,
  input  logic               stat_en_i,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [CODE_W-1:0]  grp_code_i,
  input  logic [SEL_W-1:0]   test_sel_i,
  output logic               cond_o,
  output logic [DATA_W-1:0]  stat_word_o
);
  flags_t set_mask, clr_mask, flags;
  logic [FLAG_W-1:0] flag_vec;

  flag_grp_dec i_set_dec (.en_i(set_i), .code_i(grp_code_i), .mask_o(set_mask));
  flag_grp_dec i_clr_dec (.en_i(clr_i), .code_i(grp_code_i), .mask_o(clr_mask));

  flag_reg i_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_en_i     (stat_en_i),
    .alu_flags_i (alu_flags_i),
    .set_mask_i  (set_mask),
    .clr_mask_i  (clr_mask),
    .q_o         (flags)
  );

  flag_cond_mux i_mux (.flags_i(flags), .sel_i(test_sel_i), .cond_o(cond_o));

  assign flag_vec    = flags;
  assign stat_word_o = DATA_W'(flag_vec);
endmodule

// File: rtl/flag_test_unit_chk.sv
module flag_test_unit_chk
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ARITH_W-1:0] alu_flags_i,
  input logic               stat_en_i,
  input logic               set_i,
  input logic               clr_i,
  input logic [CODE_W-1:0]  grp_code_i,
  input logic [SEL_W-1:0]   test_sel_i,
  input logic               cond_o,
  input logic [DATA_W-1:0]  stat_word_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_en_i && !set_i && !clr_i |=> stat_word_o[3:0] == $past(alu_flags_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_en_i && !set_i && !clr_i |=> $stable(stat_word_o));

  p_set_link_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i && grp_code_i == GRP_LINK |=> stat_word_o[4]);

  p_clr_usr1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i && grp_code_i == GRP_USR1 |=> !stat_word_o[5]);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i && grp_code_i == GRP_USR3 |=> stat_word_o[7]);

  p_cmd_over_alu_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_en_i && clr_i && !set_i && grp_code_i == GRP_ARITH |=> stat_word_o[3:0] == 4'h0);

  p_eq_tracks_z_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_sel_i == 4'h2 |-> cond_o == stat_word_o[0]);

  p_unused_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_sel_i >= 4'hC |-> !cond_o);
endmodule

bind flag_test_unit flag_test_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alu_flags_i (alu_flags_i),
  .stat_en_i   (stat_en_i),
  .set_i       (set_i),
  .clr_i       (clr_i),
  .grp_code_i  (grp_code_i),
  .test_sel_i  (test_sel_i),
  .cond_o      (cond_o),
  .stat_word_o (stat_word_o)
);

// File: tb/test_flag_test_unit.sv
module test_flag_test_unit;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        alu_flags = '0;
  logic              stat_en = 1'b0;
  logic              set_c = 1'b0;
  logic              clr_c = 1'b0;
  logic [4:0]        code = '0;
  logic [3:0]        sel = '0;
  logic              cond;
  logic [DATA_W-1:0] word;

  int   n_chk = 0;
  int   n_err = 0;
  logic [7:0] exp_f = '0;
  bit   done = 0;

  always #10 clk = ~clk;

  flag_test_unit #(.DATA_W(DATA_W)) i_flag_test_unit (
    .clk_i(clk), .rst_ni(rst_ni), .alu_flags_i(alu_flags), .stat_en_i(stat_en),
    .set_i(set_c), .clr_i(clr_c), .grp_code_i(code), .test_sel_i(sel),
    .cond_o(cond), .stat_word_o(word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] grp_mask(input logic [4:0] c);
    case (c)
      5'd3:    return 8'h0F;
      5'd5:    return 8'h10;
      5'd6:    return 8'h20;
      5'd9:    return 8'h40;
      5'd10:   return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_cond(input logic [7:0] f, input logic [3:0] s);
    logic z, c, n, v;
    z = f[0]; c = f[1]; n = f[2]; v = f[3];
    case (s)
      4'h0: return (n != v) || z;
      4'h1: return n != v;
      4'h2: return z;
      4'h3: return v;
      4'h4: return !c || z;
      4'h5: return c;
      4'h6: return z || c;
      4'h7: return n;
      4'h8: return f[4];
      4'h9: return f[5];
      4'hA: return f[6];
      4'hB: return f[7];
      default: return 1'b0;
    endcase
  endfunction

  // one clocked operation; result sampled at the following falling edge
  task automatic step(input bit en, input logic [3:0] alu, input bit s, input bit c, input logic [4:0] gc);
    logic [7:0] m;
    @(negedge clk);
    stat_en = en; alu_flags = alu; set_c = s; clr_c = c; code = gc;
    @(negedge clk);
    stat_en = 0; set_c = 0; clr_c = 0;
    m = en ? {exp_f[7:4], alu} : exp_f;
    if (c) m = m & ~grp_mask(gc);
    if (s) m = m | grp_mask(gc);
    exp_f = m;
  endtask

  task automatic chk_word(input string req);
    chk(word == DATA_W'(exp_f), req, word, DATA_W'(exp_f));
  endtask

  task automatic sweep_sel(input string req);
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      #1;
      chk(cond == exp_cond(exp_f, 4'(s)), req, cond, exp_cond(exp_f, 4'(s)));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(word == '0, "R1 reset word", word, 0);
    sweep_sel("R1 reset conditions");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R9 R11: every ALU pattern, every select
    for (int v = 0; v < 16; v++) begin
      step(1, 4'(v), 0, 0, 5'd0);
      chk_word("R2 alu load");
      sweep_sel("R9 arithmetic condition");
    end

    // R3: disabled load holds
    step(1, 4'h6, 0, 0, 5'd0);
    step(0, 4'h9, 0, 0, 5'd0);
    chk(word[3:0] == 4'h6, "R3 hold without enable", word[3:0], 4'h6);

    // R4 R8: set from all-clear, all codes
    for (int g = 0; g < 32; g++) begin
      step(0, 4'h0, 0, 1, 5'd3);
      for (int k = 0; k < 4; k++) step(0, 4'h0, 0, 1, (k == 0) ? 5'd5 : (k == 1) ? 5'd6 : (k == 2) ? 5'd9 : 5'd10);
      chk(word == '0, "R5 cleared before set", word, 0);
      step(0, 4'h0, 1, 0, 5'(g));
      chk_word("R4 set group");
      chk(word[DATA_W-1:8] == '0, "R8 upper bits zero", word, DATA_W'(exp_f));
    end

    // R5: clear from all-set, all codes
    for (int g = 0; g < 32; g++) begin
      step(0, 4'h0, 1, 0, 5'd3);
      for (int k = 0; k < 4; k++) step(0, 4'h0, 1, 0, (k == 0) ? 5'd5 : (k == 1) ? 5'd6 : (k == 2) ? 5'd9 : 5'd10);
      chk(word == 16'h00FF, "R4 all set", word, 16'h00FF);
      step(0, 4'h0, 0, 1, 5'(g));
      chk_word("R5 clear group");
    end

    // R10: link and user flags on their selects, with patterned word
    step(0, 4'h0, 0, 1, 5'd5);
    step(0, 4'h0, 0, 1, 5'd9);
    chk(word == 16'h00AF, "R8 layout after partial clear", word, 16'h00AF);
    sweep_sel("R10 single-flag selects");
    step(0, 4'h0, 1, 0, 5'd5);
    step(0, 4'h0, 0, 1, 5'd6);
    sweep_sel("R10 single-flag selects swapped");

    // R6: set and clear together
    step(0, 4'h0, 0, 1, 5'd10);
    step(0, 4'h0, 1, 1, 5'd10);
    chk(word[7] == 1'b1, "R6 set wins", word[7], 1);
    step(0, 4'h0, 0, 1, 5'd3);
    step(0, 4'h0, 1, 1, 5'd3);
    chk(word[3:0] == 4'hF, "R6 set wins arith", word[3:0], 4'hF);

    // R7: command against ALU load
    step(1, 4'hF, 0, 1, 5'd3);
    chk(word[3:0] == 4'h0, "R7 clear overrides load", word[3:0], 0);
    step(1, 4'h0, 1, 0, 5'd3);
    chk(word[3:0] == 4'hF, "R7 set overrides load", word[3:0], 4'hF);
    step(0, 4'h0, 0, 1, 5'd5);
    step(1, 4'hA, 1, 0, 5'd5);
    chk(word[4:0] == 5'h1A, "R7 link cmd keeps load", word[4:0], 5'h1A);
    step(1, 4'h5, 0, 1, 5'd6);
    chk_word("R7 user clear keeps load");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    chk(word == '0, "R1 async reset", word, 0);
    exp_f = '0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule